// File: doc/BRIEF.md
# Package Low-Power State Resolver

This block merges the idle depth reported by each of several processor cores into one package-level power state: active, C3 or C6. The package can only be as deep as its shallowest core, so the block takes the minimum of the per-core codes as its target. Before it leaves the active state, it asks the platform for permission through a request line and waits for a grant.

A separate deep grant decides whether the package may go all the way to C6. If the general grant arrives without the deep grant, the package settles in C3. Once the package is in C6, it stays there only while the shared last-level cache reports activity. If that activity stops, the package falls back to C3. While the package is in either low-power state, the cache-retain output tells the cache that its contents are still valid.

When any core wakes to C0 or C1, the package returns to active on the next clock and withdraws any open request. The package state is held in a register and changes at most once per clock.

Top module: `pkg_lowpower_resolver`

## Requirements
- R1: After reset, pkgState is 00 (active), pkgReq is 0 and cacheRetain is 0.
- R2: Each core reports a 2-bit code ordered by depth (00 = C0, 01 = C1, 10 = C3, 11 = C6), and the target is the minimum over all cores. When the package is active and the target is 10 or 11, pkgReq is 1 after the next clock.
- R3: pkgReq stays high until a grant is taken or the target becomes shallower than C3. A platGrant that arrives while no request is outstanding has no effect on pkgState.
- R4: If the package is active, a request is outstanding, platGrant is 1 and the target is C3, pkgState becomes 01 (C3) on the next clock and pkgReq drops.
- R5: If the package is active, a request is outstanding, platGrant, deepGrant and cacheActive are all 1 and every core reports C6, pkgState becomes 10 (C6) on the next clock and pkgReq drops.
- R6: A granted request with a C6 target but deepGrant at 0 makes pkgState 01 (C3), not C6.
- R7: In C6, cacheActive at 0 moves pkgState to 01 (C3) on the next clock.
- R8: Any core at 00 or 01 makes pkgState 00 and pkgReq 0 on the next clock.
- R9: cacheRetain is 1 exactly when pkgState is 01 or 10.
- R10: In C3, a C6 target together with deepGrant and cacheActive moves pkgState to C6 without a new request. In C6, a target of C3 moves pkgState back to 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coreState | input | 2*NUM_CORES | Per-core depth codes; core i uses bits [2i+1:2i] |
| platGrant | input | 1 | Platform permission for a low-power package state |
| deepGrant | input | 1 | Platform grant of the C6 request |
| cacheActive | input | 1 | Some part of the shared cache is still active |
| pkgState | output | 2 | Package state: 00 active, 01 C3, 10 C6 |
| pkgReq | output | 1 | Request to the platform for a low-power entry |
| cacheRetain | output | 1 | Shared cache contents are valid and retained |

## Verification
The assertions assume that coreState, the two grants and cacheActive are steady around each rising edge and may change freely from cycle to cycle. They do not assume that a grant follows a request: the block itself must ignore a grant that arrives without one. The stimulus is driven on falling edges. Core codes are skewed toward C3 and C6 so that entries, fallbacks and wakes all happen often. Grants and cache activity are random and unrelated to the request line, so both stray grants and the deep-grant-missing path are exercised.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CORE_C3 = 2'b10;
  localparam logic [CODE_W-1:0] CORE_C6 = 2'b11;

  typedef enum logic [1:0] {
    PKG_ACTIVE = 2'b00,
    PKG_C3     = 2'b01,
    PKG_C6     = 2'b10
  } pkgState_e;

  typedef struct packed {
    logic      loadState;
    pkgState_e nextState;
    logic      setReq;
    logic      clrReq;
  } ctrlStrobe_t;
endpackage

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CORES*CODE_W-1:0]   coreState,
  input  ctrlStrobe_t                   strobe,
  output logic [CODE_W-1:0]             tgtDepth,
  output pkgState_e                     curState,
  output logic                          reqQ
);
  logic [CODE_W-1:0] minStage [NUM_CORES];

  assign minStage[0] = coreState[CODE_W-1:0];

  generate
    for (genvar i = 1; i < NUM_CORES; i++) begin : g_min
      logic [CODE_W-1:0] coreCode;
      assign coreCode    = coreState[i*CODE_W +: CODE_W];
      assign minStage[i] = (coreCode < minStage[i-1]) ? coreCode : minStage[i-1];
    end
  endgenerate

  assign tgtDepth = minStage[NUM_CORES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curState <= PKG_ACTIVE;
      reqQ     <= 1'b0;
    end else begin
      if (strobe.loadState) curState <= strobe.nextState;
      if (strobe.clrReq)      reqQ <= 1'b0;
      else if (strobe.setReq) reqQ <= 1'b1;
    end
  end
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic [CODE_W-1:0] tgtDepth,
  input  pkgState_e         curState,
  input  logic              reqQ,
  input  logic              platGrant,
  input  logic              deepGrant,
  input  logic              cacheActive,
  output ctrlStrobe_t       strobe
);
  logic tgtLow;
  logic deepOk;

  assign tgtLow = (tgtDepth >= CORE_C3);
  assign deepOk = (tgtDepth == CORE_C6) && deepGrant && cacheActive;

  always_comb begin
    strobe           = '0;
    strobe.nextState = curState;
    if (!tgtLow) begin
      strobe.loadState = 1'b1;
      strobe.nextState = PKG_ACTIVE;
      strobe.clrReq    = 1'b1;
    end else begin
      unique case (curState)
        PKG_ACTIVE: begin
          if (reqQ && platGrant) begin
            strobe.loadState = 1'b1;
            strobe.nextState = deepOk ? PKG_C6 : PKG_C3;
            strobe.clrReq    = 1'b1;
          end else begin
            strobe.setReq = 1'b1;
          end
        end
        PKG_C3: begin
          if (deepOk) begin
            strobe.loadState = 1'b1;
            strobe.nextState = PKG_C6;
          end
        end
        PKG_C6: begin
          if ((tgtDepth != CORE_C6) || !cacheActive) begin
            strobe.loadState = 1'b1;
            strobe.nextState = PKG_C3;
          end
        end
        default: begin
          strobe.loadState = 1'b1;
          strobe.nextState = PKG_ACTIVE;
          strobe.clrReq    = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pkg_lowpower_resolver.sv
module pkg_lowpower_resolver
  import psr_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*2-1:0]       coreState,
  input  logic                         platGrant,
  input  logic                         deepGrant,
  input  logic                         cacheActive,
  output logic [1:0]                   pkgState,
  output logic                         pkgReq,
  output logic                         cacheRetain
);
  ctrlStrobe_t       strobe;
  logic [CODE_W-1:0] tgtDepth;
  pkgState_e         curState;
  logic              reqQ;

  psr_datapath #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .coreState (coreState),
    .strobe    (strobe),
    .tgtDepth  (tgtDepth),
    .curState  (curState),
    .reqQ      (reqQ)
  );

  psr_ctrl u_ctrl (
    .tgtDepth    (tgtDepth),
    .curState    (curState),
    .reqQ        (reqQ),
    .platGrant   (platGrant),
    .deepGrant   (deepGrant),
    .cacheActive (cacheActive),
    .strobe      (strobe)
  );

  assign pkgState    = curState;
  assign pkgReq      = reqQ;
  assign cacheRetain = (curState != PKG_ACTIVE);
endmodule

// File: rtl/pkg_lowpower_resolver_checker.sv
module pkg_lowpower_resolver_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CORES*2-1:0] coreState,
  input logic                   platGrant,
  input logic                   deepGrant,
  input logic                   cacheActive,
  input logic [1:0]             pkgState,
  input logic                   pkgReq,
  input logic                   cacheRetain
);
  logic [1:0] minCode;

  always_comb begin
    minCode = 2'b11;
    for (int i = 0; i < NUM_CORES; i++)
      if (coreState[i*2 +: 2] < minCode) minCode = coreState[i*2 +: 2];
  end

  AST_WAKE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (minCode < 2'b10) |=> (pkgState == 2'b00 && !pkgReq)); // R8

  AST_LOW_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState != 2'b00 && $past(pkgState) == 2'b00) |-> $past(pkgReq && platGrant)); // R4

  AST_C6_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState == 2'b10 && $past(pkgState) != 2'b10) |->
      $past(minCode == 2'b11 && deepGrant && cacheActive)); // R5

  AST_C6_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState == 2'b10) |-> $past(cacheActive)); // R7

  AST_REQ_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pkgReq |-> (pkgState == 2'b00)); // R3

  AST_RETAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cacheRetain |-> (pkgState == 2'b01 || pkgState == 2'b10)); // R9

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pkgState != 2'b11); // R1
endmodule

bind pkg_lowpower_resolver pkg_lowpower_resolver_checker #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/pkg_lowpower_resolver_bench.sv
module pkg_lowpower_resolver_bench;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*2-1:0] coreState = '0;
  logic           platGrant = 1'b0;
  logic           deepGrant = 1'b0;
  logic           cacheActive = 1'b0;
  logic [1:0]     pkgState;
  logic           pkgReq;
  logic           cacheRetain;

  int tests = 0;
  int fails = 0;
  logic [1:0] mSt = 2'b00;
  logic       mReq = 1'b0;
  string      mTag;

  always #4 clk = ~clk;

  pkg_lowpower_resolver #(.NUM_CORES(N)) u_pkg_lowpower_resolver (
    .clk(clk), .rst_n(rst_n), .coreState(coreState), .platGrant(platGrant),
    .deepGrant(deepGrant), .cacheActive(cacheActive), .pkgState(pkgState),
    .pkgReq(pkgReq), .cacheRetain(cacheRetain));

  function automatic logic [N*2-1:0] allCores(input logic [1:0] code);
    logic [N*2-1:0] v;
    for (int i = 0; i < N; i++) v[i*2 +: 2] = code;
    return v;
  endfunction

  function automatic logic [1:0] minOf(input logic [N*2-1:0] cs);
    logic [1:0] m = 2'b11;
    for (int i = 0; i < N; i++) if (cs[i*2 +: 2] < m) m = cs[i*2 +: 2];
    return m;
  endfunction

  task automatic modelStep(input logic [N*2-1:0] cs, input logic g, input logic d, input logic c);
    logic [1:0] t = minOf(cs);
    logic deepOk = (t == 2'b11) && d && c;
    if (t < 2'b10) begin
      mSt = 2'b00; mReq = 1'b0; mTag = "R8";
    end else if (mSt == 2'b00) begin
      if (mReq && g) begin
        mSt = deepOk ? 2'b10 : 2'b01; mReq = 1'b0;
        mTag = deepOk ? "R5" : ((t == 2'b11) ? "R6" : "R4");
      end else begin
        mTag = mReq ? "R3" : "R2"; mReq = 1'b1;
      end
    end else if (mSt == 2'b01) begin
      if (deepOk) mSt = 2'b10;
      mTag = "R10";
    end else begin
      if (!c) begin mSt = 2'b01; mTag = "R7"; end
      else if (t != 2'b11) begin mSt = 2'b01; mTag = "R10"; end
      else mTag = "R5";
    end
  endtask

  task automatic check(input string tag);
    tests++;
    if (pkgState !== mSt || pkgReq !== mReq) begin
      fails++;
      $display("FAIL %s: state=%b req=%b expected state=%b req=%b", tag, pkgState, pkgReq, mSt, mReq);
    end
    tests++;
    if (cacheRetain !== (mSt != 2'b00)) begin
      fails++;
      $display("FAIL R9: cacheRetain=%b expected %b", cacheRetain, (mSt != 2'b00));
    end
  endtask

  task automatic step(input logic [N*2-1:0] cs, input logic g, input logic d, input logic c, input string tag);
    coreState = cs; platGrant = g; deepGrant = d; cacheActive = c;
    modelStep(cs, g, d, c);
    @(negedge clk);
    check(tag == "" ? mTag : tag);
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N*2-1:0] cs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    step(allCores(2'b10), 0, 0, 0, "R2");
    step(allCores(2'b10), 0, 0, 0, "R3");
    cs = allCores(2'b10); cs[1:0] = 2'b00;
    step(cs, 0, 0, 0, "R8");
    step(allCores(2'b11), 1, 1, 1, "R3");
    step(allCores(2'b11), 1, 1, 1, "R5");
    step(allCores(2'b11), 0, 0, 0, "R7");
    step(allCores(2'b11), 0, 1, 1, "R10");
    cs = allCores(2'b11); cs[5:4] = 2'b10;
    step(cs, 0, 1, 1, "R10");
    cs[3:2] = 2'b01;
    step(cs, 0, 0, 0, "R8");
    step(allCores(2'b11), 0, 0, 1, "R2");
    step(allCores(2'b11), 1, 0, 1, "R6");
    step(allCores(2'b00), 0, 0, 0, "R8");
    cs = allCores(2'b11); cs[7:6] = 2'b10;
    step(cs, 0, 0, 1, "R2");
    step(cs, 1, 1, 1, "R4");

    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < N; i++)
        cs[i*2 +: 2] = ($urandom % 12 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
      step(cs, 1'($urandom % 3 == 0), 1'($urandom % 2), 1'($urandom % 5 != 0), "");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule